// File: doc/BRIEF.md
# Converter Command-Channel Register Front End

This block is a 32-bit memory-mapped slave placed in front of a bank of 16-bit converter registers. Software reaches it through seven word offsets that hold configuration, interrupt status, interrupt mask, a read-only status word, a write-only command port, a read-only result port and a master-control word. Command words written to the command port are decoded and carried out in the same cycle against the internal bank. Each accepted command leaves one 16-bit result in a small result queue, and software drains that queue through the result port.

Because commands never wait, the command path always reports itself empty and below threshold. A command is thrown away when the master-control hold bit is set, or when a read or write names a register beyond the bank. A single level interrupt output combines the sticky status bits with the mask. Every bus access completes in the cycle it is presented: read data is combinational from the current state, and all state changes at the next rising clock edge.

Top module: `cmdfe_top`

## Requirements
- R1: After reset, configuration reads 0x00001814, interrupt status reads 0x00000200, interrupt mask reads 0xFFFFFFFF, master control reads 0x00000010, and every bank register reads 0.
- R2: Word offsets are 0 configuration, 1 interrupt status, 2 interrupt mask, 3 status, 4 command port, 5 result port, 6 master control. Offsets 3 and 5 are read-only, offset 4 is write-only, and 0, 1, 2 and 6 are read/write. A disallowed access, or any offset of 7, reads 0 and changes nothing.
- R3: A command word holds the opcode in bits 29:26, the register index in bits 25:16 and the data in bits 15:0, with opcode 0 no-op, 1 read and 2 write. A write command stores the data in the indexed register and queues a result of 0.
- R4: A read command queues the indexed register's value. Results leave the result port in the order they were queued, and a read of the empty port returns 0.
- R5: A no-op queues a result of 0 whatever its index.
- R6: While master-control bit 4 is 1, every command-port write is discarded.
- R7: A read or write command whose index is at or above the bank size (default 32) is discarded and touches no register.
- R8: Writing interrupt status clears each bit written as 1. Bit 9 (command path below threshold) is set again after every permitted access.
- R9: A write to the interrupt mask keeps only bits 9:0. A write to master control stores the value ANDed with 0x00FFFEFF.
- R10: irq_o is high exactly when some interrupt-status bit is 1 while its mask bit is 0.
- R11: After any permitted access that leaves the result-queue level above configuration bits 19:16, interrupt-status bit 8 is set. It stays set until it is cleared.
- R12: Status reads the queue level in bits 15:12, queue full in bit 9, queue empty in bit 8 and command path empty in bit 10, with all other bits 0. A result queued while the queue holds its depth (default 15) is dropped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Access request for this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 3 | Word offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the request |
| irq_o | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is the threshold bit coming back at once after software clears it. That happens only while the queue level stays above the threshold, so it needs a raised threshold, several queued no-ops and a clear that is not preceded by any pop. The stimulus reaches it by stacking three no-ops over a threshold of 2, clearing bit 8, and reading it back as set. It then pops one entry and clears again, and this time the bit stays clear. A second hard case is filling the queue exactly to its depth so that one more command is dropped. The bench fills it with no-ops that end in a read of a known register, so the dropped result can be told apart when the queue drains.

// File: rtl/cmdfe_pkg.sv
package cmdfe_pkg;
  localparam logic [2:0] OFF_CFG  = 3'd0;
  localparam logic [2:0] OFF_ISTS = 3'd1;
  localparam logic [2:0] OFF_IMSK = 3'd2;
  localparam logic [2:0] OFF_STAT = 3'd3;
  localparam logic [2:0] OFF_CMD  = 3'd4;
  localparam logic [2:0] OFF_RES  = 3'd5;
  localparam logic [2:0] OFF_MCTL = 3'd6;

  localparam logic [3:0] OP_NOP = 4'd0;
  localparam logic [3:0] OP_RD  = 4'd1;
  localparam logic [3:0] OP_WR  = 4'd2;

  localparam logic [31:0] CFG_RST   = 32'h0000_1814;
  localparam logic [31:0] ISTS_RST  = 32'h0000_0200;
  localparam logic [31:0] IMSK_RST  = 32'hFFFF_FFFF;
  localparam logic [31:0] MCTL_RST  = 32'h0000_0010;
  localparam logic [31:0] IMSK_KEEP = 32'h0000_03FF;
  localparam logic [31:0] MCTL_KEEP = 32'h00FF_FEFF;

  localparam int unsigned ISTS_CLTH = 9;
  localparam int unsigned ISTS_DGTH = 8;
  localparam int unsigned MCTL_HOLD = 4;
  localparam int unsigned THR_LSB   = 16;
  localparam int unsigned THR_W     = 4;
  localparam int unsigned LVL_W     = 4;
endpackage

// File: rtl/cmdfe_decode.sv
module cmdfe_decode #(
  parameter int unsigned NREG  = 32,
  parameter int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              vld_i,
  input  logic              hold_i,
  input  logic [29:0]       word_i,
  output logic              bank_we_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic [15:0]       data_o,
  output logic              push_o,
  output logic              push_bank_o
);
  import cmdfe_pkg::*;

  logic [3:0] op;
  logic [9:0] idx_full;
  logic       in_rng, live, is_nop, is_rd, is_wr;

  assign op       = word_i[29:26];
  assign idx_full = word_i[25:16];
  assign data_o   = word_i[15:0];
  assign idx_o    = idx_full[IDX_W-1:0];

  assign in_rng = (32'(idx_full) < NREG);
  assign live   = vld_i & ~hold_i;
  assign is_nop = (op == OP_NOP);
  assign is_rd  = (op == OP_RD);
  assign is_wr  = (op == OP_WR);

  assign bank_we_o   = live & is_wr & in_rng;
  assign push_o      = live & (is_nop | ((is_rd | is_wr) & in_rng));
  assign push_bank_o = is_rd;
endmodule

// File: rtl/cmdfe_bank.sv
module cmdfe_bank #(
  parameter int unsigned NREG  = 32,
  parameter int unsigned IDX_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [15:0]       wdata_i,
  output logic [15:0]       rdata_o
);
  logic [15:0] mem_q [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[idx_i] <= wdata_i;
    end
  end

  assign rdata_o = mem_q[idx_i];
endmodule

// File: rtl/cmdfe_resq.sv
module cmdfe_resq #(
  parameter int unsigned DEPTH = 15,
  parameter int unsigned CW    = $clog2(DEPTH + 1),
  parameter int unsigned PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          push_i,
  input  logic [15:0]   pdata_i,
  input  logic          pop_i,
  output logic [15:0]   head_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] cnt_nxt_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [15:0]   mem_q [DEPTH];
  logic [PW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (32'(cnt_q) == DEPTH);
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i & ~full_o;
  assign pop_ok  = pop_i & ~empty_o;

  function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
    return (32'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    cnt_nxt_o = cnt_q;
    if (push_ok) cnt_nxt_o = cnt_q + 1'b1;
    else if (pop_ok) cnt_nxt_o = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_ok) begin
        mem_q[wp_q] <= pdata_i;
        wp_q        <= wrap_inc(wp_q);
      end
      if (pop_ok) rp_q <= wrap_inc(rp_q);
      cnt_q <= cnt_nxt_o;
    end
  end

  assign head_o = empty_o ? 16'h0 : mem_q[rp_q];
  assign cnt_o  = cnt_q;

  p_no_overflow_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(cnt_q) <= DEPTH);
  p_full_drop_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i) |=> (32'(cnt_q) == DEPTH));
  p_empty_pop_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pop_i && empty_o && !push_i) |=> empty_o);
endmodule

// File: rtl/cmdfe_top.sv
module cmdfe_top #(
  parameter int unsigned NREG  = 32,
  parameter int unsigned DEPTH = 15
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_i,
  input  logic        we_i,
  input  logic [2:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  output logic        irq_o
);
  import cmdfe_pkg::*;

  localparam int unsigned IDX_W = $clog2(NREG);
  localparam int unsigned CW    = $clog2(DEPTH + 1);

  logic [31:0] cfg_q, ists_q, imsk_q, mctl_q;
  logic        rd_ok, wr_ok, rd_acc, wr_acc, any_acc;
  logic        cmd_vld, pop;

  logic             bank_we, push, push_bank;
  logic [IDX_W-1:0] idx;
  logic [15:0]      cdata, bank_rd, head;
  logic [CW-1:0]    cnt, cnt_nxt;
  logic             q_full, q_empty;
  logic [THR_W-1:0] thr;

  // access direction per offset
  always_comb begin
    rd_ok = 1'b0;
    wr_ok = 1'b0;
    unique case (addr_i)
      OFF_CFG, OFF_ISTS, OFF_IMSK, OFF_MCTL: begin rd_ok = 1'b1; wr_ok = 1'b1; end
      OFF_STAT, OFF_RES: rd_ok = 1'b1;
      OFF_CMD:           wr_ok = 1'b1;
      default: ;
    endcase
  end

  assign rd_acc  = req_i & ~we_i & rd_ok;
  assign wr_acc  = req_i & we_i & wr_ok;
  assign any_acc = rd_acc | wr_acc;
  assign cmd_vld = wr_acc & (addr_i == OFF_CMD);
  assign pop     = rd_acc & (addr_i == OFF_RES);
  assign thr     = cfg_q[THR_LSB +: THR_W];

  cmdfe_decode #(.NREG(NREG), .IDX_W(IDX_W)) u_dec (
    .vld_i       (cmd_vld),
    .hold_i      (mctl_q[MCTL_HOLD]),
    .word_i      (wdata_i[29:0]),
    .bank_we_o   (bank_we),
    .idx_o       (idx),
    .data_o      (cdata),
    .push_o      (push),
    .push_bank_o (push_bank)
  );

  cmdfe_bank #(.NREG(NREG), .IDX_W(IDX_W)) u_bank (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (bank_we),
    .idx_i   (idx),
    .wdata_i (cdata),
    .rdata_o (bank_rd)
  );

  cmdfe_resq #(.DEPTH(DEPTH), .CW(CW)) u_resq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .push_i    (push),
    .pdata_i   (push_bank ? bank_rd : 16'h0),
    .pop_i     (pop),
    .head_o    (head),
    .cnt_o     (cnt),
    .cnt_nxt_o (cnt_nxt),
    .full_o    (q_full),
    .empty_o   (q_empty)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q  <= CFG_RST;
      ists_q <= ISTS_RST;
      imsk_q <= IMSK_RST;
      mctl_q <= MCTL_RST;
    end else begin
      if (wr_acc && addr_i == OFF_CFG)  cfg_q  <= wdata_i;
      if (wr_acc && addr_i == OFF_IMSK) imsk_q <= wdata_i & IMSK_KEEP;
      if (wr_acc && addr_i == OFF_MCTL) mctl_q <= wdata_i & MCTL_KEEP;
      if (any_acc) begin
        logic [31:0] n;
        n = ists_q;
        if (wr_acc && addr_i == OFF_ISTS) n = n & ~wdata_i;
        n[ISTS_CLTH] = 1'b1;
        if (32'(cnt_nxt) > 32'(thr)) n[ISTS_DGTH] = 1'b1;
        ists_q <= n;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_acc) begin
      unique case (addr_i)
        OFF_CFG:  rdata_o = cfg_q;
        OFF_ISTS: rdata_o = ists_q;
        OFF_IMSK: rdata_o = imsk_q;
        OFF_MCTL: rdata_o = mctl_q;
        OFF_RES:  rdata_o = {16'h0, head};
        OFF_STAT: begin
          rdata_o[15:12] = LVL_W'(cnt);
          rdata_o[10]    = 1'b1;
          rdata_o[9]     = q_full;
          rdata_o[8]     = q_empty;
        end
        default: ;
      endcase
    end
  end

  assign irq_o = |(ists_q & ~imsk_q);

  p_lth_rearm_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_acc |=> ists_q[ISTS_CLTH]);
  p_gth_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (any_acc && (32'(cnt_nxt) > 32'(thr))) |=> ists_q[ISTS_DGTH]);
  p_imsk_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && addr_i == OFF_IMSK) |=> (imsk_q[31:10] == '0));
  p_mctl_keep_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_acc && addr_i == OFF_MCTL) |=> (!mctl_q[8] && mctl_q[31:24] == '0));
  p_hold_drop_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_vld && mctl_q[MCTL_HOLD]) |=> $stable(cnt));
  p_bad_access_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !any_acc) |=> ($stable(cfg_q) && $stable(imsk_q) && $stable(mctl_q) && $stable(cnt)));
  p_bad_read_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !we_i && !rd_ok) |-> (rdata_o == '0));
endmodule

// File: tb/tb_cmdfe_top.sv
module tb_cmdfe_top;
  localparam int unsigned DEPTH = 15;
  localparam logic [1:0] K_WR = 2'd0, K_RD = 2'd1, K_IRQ = 2'd2;

  typedef struct packed {
    logic [1:0]  k;
    logic [2:0]  a;
    logic [31:0] d;
    logic [31:0] e;
    logic [3:0]  r;
  } vec_t;

  localparam int NV = 62;
  localparam vec_t VEC [NV] = '{
    '{K_RD, 3'd0, 32'h0, 32'h0000_1814, 4'd1},  // R1 cfg
    '{K_RD, 3'd1, 32'h0, 32'h0000_0200, 4'd1},  // R1 ists
    '{K_RD, 3'd2, 32'h0, 32'hFFFF_FFFF, 4'd1},  // R1 mask
    '{K_RD, 3'd6, 32'h0, 32'h0000_0010, 4'd1},  // R1 mctl
    '{K_RD, 3'd3, 32'h0, 32'h0000_0500, 4'd12}, // R12 empty status
    '{K_IRQ,3'd0, 32'h0, 32'h0,         4'd10}, // R10 all masked
    '{K_WR, 3'd4, 32'h0805_1234, 32'h0, 4'd6},  // R6 dropped under hold
    '{K_RD, 3'd3, 32'h0, 32'h0000_0500, 4'd6},  // R6
    '{K_WR, 3'd6, 32'hFFFF_FFFF, 32'h0, 4'd9},
    '{K_RD, 3'd6, 32'h0, 32'h00FF_FEFF, 4'd9},  // R9 mctl and-mask
    '{K_WR, 3'd6, 32'h0, 32'h0, 4'd6},
    '{K_WR, 3'd4, 32'h0805_1234, 32'h0, 4'd3},  // R3 write reg5
    '{K_RD, 3'd3, 32'h0, 32'h0000_1400, 4'd3},  // R3 one result
    '{K_WR, 3'd4, 32'h081F_A5A5, 32'h0, 4'd3},  // R3 write reg31
    '{K_WR, 3'd4, 32'h0405_0000, 32'h0, 4'd4},  // R4 read reg5
    '{K_WR, 3'd4, 32'h041F_0000, 32'h0, 4'd4},  // R4 read reg31
    '{K_RD, 3'd3, 32'h0, 32'h0000_4400, 4'd12}, // R12 level 4
    '{K_RD, 3'd5, 32'h0, 32'h0000_0000, 4'd3},  // R3 write result 0
    '{K_RD, 3'd5, 32'h0, 32'h0000_0000, 4'd3},  // R3
    '{K_RD, 3'd5, 32'h0, 32'h0000_1234, 4'd4},  // R4 order
    '{K_RD, 3'd5, 32'h0, 32'h0000_A5A5, 4'd4},  // R4 order
    '{K_RD, 3'd5, 32'h0, 32'h0000_0000, 4'd4},  // R4 empty pop
    '{K_RD, 3'd3, 32'h0, 32'h0000_0500, 4'd4},  // R4 still empty
    '{K_WR, 3'd4, 32'h03FF_0000, 32'h0, 4'd5},  // R5 nop idx 1023
    '{K_WR, 3'd4, 32'h0420_0000, 32'h0, 4'd7},  // R7 read idx 32
    '{K_WR, 3'd4, 32'h0828_BEEF, 32'h0, 4'd7},  // R7 write idx 40
    '{K_RD, 3'd3, 32'h0, 32'h0000_1400, 4'd7},  // R7 only nop queued
    '{K_RD, 3'd5, 32'h0, 32'h0000_0000, 4'd5},  // R5 nop result
    '{K_WR, 3'd4, 32'h0408_0000, 32'h0, 4'd7},  // read reg8 (alias of 40)
    '{K_RD, 3'd5, 32'h0, 32'h0000_0000, 4'd7},  // R7 reg8 untouched
    '{K_WR, 3'd2, 32'hFFFF_FFFF, 32'h0, 4'd9},
    '{K_RD, 3'd2, 32'h0, 32'h0000_03FF, 4'd9},  // R9 mask bits
    '{K_WR, 3'd1, 32'hFFFF_FFFF, 32'h0, 4'd8},
    '{K_RD, 3'd1, 32'h0, 32'h0000_0200, 4'd8},  // R8 clear and rearm
    '{K_WR, 3'd3, 32'h1234_5678, 32'h0, 4'd2},  // status is read-only
    '{K_RD, 3'd3, 32'h0, 32'h0000_0500, 4'd2},  // R2
    '{K_RD, 3'd4, 32'h0, 32'h0000_0000, 4'd2},  // R2 cmd read gives 0
    '{K_RD, 3'd7, 32'h0, 32'h0000_0000, 4'd2},  // R2 offset 7
    '{K_WR, 3'd7, 32'hFFFF_FFFF, 32'h0, 4'd2},
    '{K_WR, 3'd5, 32'hFFFF_FFFF, 32'h0, 4'd2},
    '{K_RD, 3'd3, 32'h0, 32'h0000_0500, 4'd2},  // R2 nothing queued
    '{K_IRQ,3'd0, 32'h0, 32'h0,         4'd10}, // R10 bit9 masked
    '{K_WR, 3'd2, 32'h0000_01FF, 32'h0, 4'd10},
    '{K_IRQ,3'd0, 32'h0, 32'h1,         4'd10}, // R10 bit9 open
    '{K_WR, 3'd2, 32'h0000_03FF, 32'h0, 4'd10},
    '{K_WR, 3'd0, 32'h0002_1814, 32'h0, 4'd11}, // threshold 2
    '{K_RD, 3'd0, 32'h0, 32'h0002_1814, 4'd2},  // R2 cfg r/w
    '{K_WR, 3'd4, 32'h0, 32'h0, 4'd11},
    '{K_WR, 3'd4, 32'h0, 32'h0, 4'd11},
    '{K_WR, 3'd4, 32'h0, 32'h0, 4'd11},
    '{K_RD, 3'd1, 32'h0, 32'h0000_0300, 4'd11}, // R11 level 3 > 2
    '{K_WR, 3'd1, 32'h0000_0100, 32'h0, 4'd11},
    '{K_RD, 3'd1, 32'h0, 32'h0000_0300, 4'd11}, // R11 rearmed
    '{K_IRQ,3'd0, 32'h0, 32'h0,         4'd10}, // R10
    '{K_WR, 3'd2, 32'h0000_02FF, 32'h0, 4'd10},
    '{K_IRQ,3'd0, 32'h0, 32'h1,         4'd10}, // R10 bit8 open
    '{K_RD, 3'd5, 32'h0, 32'h0000_0000, 4'd11},
    '{K_WR, 3'd1, 32'h0000_0100, 32'h0, 4'd11},
    '{K_RD, 3'd1, 32'h0, 32'h0000_0200, 4'd11}, // R11 level 2 not above
    '{K_IRQ,3'd0, 32'h0, 32'h0,         4'd10}, // R10
    '{K_RD, 3'd5, 32'h0, 32'h0000_0000, 4'd4},
    '{K_RD, 3'd5, 32'h0, 32'h0000_0000, 4'd4}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_i = 1'b0;
  logic        we_i = 1'b0;
  logic [2:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        irq_o;
  int          n_chk = 0;
  int          n_err = 0;
  logic        done = 1'b0;

  always #10 clk_i = ~clk_i;

  cmdfe_top #(.NREG(32), .DEPTH(DEPTH)) dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  task automatic chk(input int r, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL R%0d: got %h expected %h", r, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(posedge clk_i); #1;
    req_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] exp, input int r);
    @(negedge clk_i);
    req_i = 1'b1; we_i = 1'b0; addr_i = a;
    #2 chk(r, rdata_o, exp);
    @(posedge clk_i); #1;
    req_i = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].k)
        K_WR:  wr(VEC[i].a, VEC[i].d);
        K_RD:  rd(VEC[i].a, VEC[i].e, int'(VEC[i].r));
        default: begin
          @(negedge clk_i);
          chk(int'(VEC[i].r), {31'h0, irq_o}, VEC[i].e);
        end
      endcase
    end

    // R12: fill to depth, last accepted result is reg5, one more dropped
    wr(3'd0, 32'h000F_1814);
    for (int i = 0; i < DEPTH - 1; i++) wr(3'd4, 32'h0);
    wr(3'd4, 32'h0405_0000);
    wr(3'd4, 32'h041F_0000);
    rd(3'd3, (32'(DEPTH) << 12) | 32'h600, 12); // R12 full status
    for (int i = 0; i < DEPTH - 1; i++) rd(3'd5, 32'h0, 12);
    rd(3'd5, 32'h0000_1234, 12);                 // R12 not overwritten
    rd(3'd5, 32'h0, 12);                         // R12 extra dropped

    // R1: reset in mid-run clears bank and registers
    @(negedge clk_i) rst_ni = 1'b0;
    @(negedge clk_i) rst_ni = 1'b1;
    rd(3'd0, 32'h0000_1814, 1);
    rd(3'd6, 32'h0000_0010, 1);
    rd(3'd3, 32'h0000_0500, 1);
    wr(3'd6, 32'h0);
    wr(3'd4, 32'h0405_0000);
    rd(3'd5, 32'h0, 1);                          // R1 reg5 cleared
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk_i);
        n_chk++; n_err++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule